// File: doc/BRIEF.md
# Connection Memory Block Fill Engine

This block fills every word of a connection memory with one fixed value in a single hardware sweep, so that software does not have to write each location itself. Software first sets a fill-enable bit in the control register. It then writes a one to a trigger bit. From that point the engine writes one memory word per clock, in ascending address order from zero up to the last word. The upper five bits of each 16-bit word receive a pattern, which is taken from a field of a host mode register. The lower eleven bits are cleared.

While the sweep runs, the engine owns the memory write port. Host writes are discarded, and a busy flag tells the host interface to answer reads with a busy indication. The trigger bit reads back as one for the whole sweep and returns to zero by itself when the last word has been written. The sweep length is bounded by two frame periods, and this bound is checked at elaboration.

Top module: `cm_fill_engine`

## Requirements
- R1: While reset is asserted and directly after it, `trig_o` and `busy_o` are 0 and no memory write is issued unless the host requests one.
- R2: A trigger write (`trig_wr_i`=1, `trig_wdata_i`=1) sampled at a clock edge while `fill_en_i`=1 and the engine is idle starts a sweep. From the next cycle `busy_o` and `trig_o` are 1 and the first write goes to address 0.
- R3: During a sweep, exactly one word is written per clock (`mem_we_o`=1), at addresses 0, 1, 2 … DEPTH-1 in that order, so every location is written once.
- R4: Each word written by the sweep equals the pattern in bits 15:11 and zero in bits 10:0. The pattern is bits 9:5 of `mode_reg_i`, captured at the start edge. The other bits of `mode_reg_i` and any later change to them have no effect on the sweep.
- R5: The sweep lasts exactly DEPTH cycles, which must not exceed 2*FRAME_CYCLES. After the cycle that writes address DEPTH-1, `trig_o` and `busy_o` return to 0 without any host action.
- R6: A trigger write while `fill_en_i`=0 has no effect. `trig_o` stays 0, no sweep starts and no memory write is issued.
- R7: While idle, a host write passes straight through in the same cycle: `mem_we_o`, `mem_addr_o` and `mem_wdata_o` equal `host_we_i`, `host_addr_i` and `host_wdata_i`.
- R8: While `busy_o`=1, host writes never reach the memory. The memory port carries only sweep writes, and `busy_o` is the busy indication for host reads.
- R9: Once started, a sweep is not affected by trigger writes (of 0 or 1) or by `fill_en_i` falling. It still runs all DEPTH cycles without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_en_i | input | 1 | Block fill enable bit from the control register |
| trig_wr_i | input | 1 | Host write strobe for the trigger bit |
| trig_wdata_i | input | 1 | Value written to the trigger bit |
| mode_reg_i | input | MODE_W (16) | Host mode register; bits 9:5 hold the fill pattern |
| host_we_i | input | 1 | Host write enable to connection memory |
| host_addr_i | input | AW (11) | Host write address |
| host_wdata_i | input | WORD_W (16) | Host write data |
| trig_o | output | 1 | Trigger bit read-back; self-clears at sweep end |
| busy_o | output | 1 | Sweep in progress; host writes blocked, reads get busy |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW (11) | Memory write address |
| mem_wdata_o | output | WORD_W (16) | Memory write data |

## Verification
The checker evaluates the following on every cycle:
- the start condition and the first address of a sweep;
- the strict address increment during a sweep;
- the cleared lower field and the stable data word during a sweep;
- the self-clearing of the trigger at the last address;
- a sweep length no greater than two frames;
- pass-through of host writes while idle;
- the fact that no sweep begins without an enabled trigger.

Other behaviours can only be shown by the bench's scenarios, because they depend on the memory contents as a whole or on what a stimulus failed to change:
- every location holds the right pattern after the sweep;
- a blocked host write left no trace;
- stray mode-register bits or a mid-sweep change of pattern were ignored.

// File: rtl/cm_fill_pkg.sv
package cm_fill_pkg;
  typedef enum logic {
    FILL_IDLE  = 1'b0,
    FILL_SWEEP = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cm_fill_ctrl.sv
module cm_fill_ctrl
  import cm_fill_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fill_en_i,
  input  logic trig_wr_i,
  input  logic trig_wdata_i,
  input  logic last_i,
  output logic start_o,
  output logic busy_o
);
  fill_state_e state_q, state_d;

  // enable is qualified only at the start edge
  assign start_o = (state_q == FILL_IDLE) && trig_wr_i && trig_wdata_i && fill_en_i;
  assign busy_o  = (state_q == FILL_SWEEP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FILL_IDLE:  if (start_o) state_d = FILL_SWEEP;
      FILL_SWEEP: if (last_i)  state_d = FILL_IDLE;
      default:    state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FILL_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/cm_fill_addr_gen.sv
module cm_fill_addr_gen #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          busy_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;

  assign addr_o = cnt_q;
  assign last_o = busy_i && (cnt_q == LAST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (busy_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cm_fill_wmux.sv
module cm_fill_wmux #(
  parameter int unsigned AW     = 11,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAT_W  = 5
) (
  input  logic              busy_i,
  input  logic [PAT_W-1:0]  pat_i,
  input  logic [AW-1:0]     sweep_addr_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  localparam int unsigned LOW_W = WORD_W - PAT_W;

  logic [WORD_W-1:0] fill_word;

  generate
    if (LOW_W > 0) begin : g_split
      assign fill_word = {pat_i, {LOW_W{1'b0}}};
    end else begin : g_full
      assign fill_word = pat_i;
    end
  endgenerate

  // sweep owns the port; host writes are dropped while busy
  assign mem_we_o    = busy_i ? 1'b1         : host_we_i;
  assign mem_addr_o  = busy_i ? sweep_addr_i : host_addr_i;
  assign mem_wdata_o = busy_i ? fill_word    : host_wdata_i;
endmodule

// File: rtl/cm_fill_engine.sv
module cm_fill_engine #(
  parameter int unsigned DEPTH        = 2048,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned PAT_W        = 5,
  parameter int unsigned MODE_W       = 16,
  parameter int unsigned PAT_LSB      = 5,
  parameter int unsigned FRAME_CYCLES = 1024,
  localparam int unsigned AW          = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_en_i,
  input  logic              trig_wr_i,
  input  logic              trig_wdata_i,
  input  logic [MODE_W-1:0] mode_reg_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic              trig_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  generate
    if (DEPTH > 2 * FRAME_CYCLES) begin : g_bad_depth
      $error("sweep longer than two frames");
    end
    if (PAT_LSB + PAT_W > MODE_W || PAT_W > WORD_W) begin : g_bad_field
      $error("pattern field out of range");
    end
  endgenerate

  logic             start;
  logic             busy;
  logic             last;
  logic [AW-1:0]    sweep_addr;
  logic [PAT_W-1:0] pat_q;
  logic [MODE_W-1:0] mode_unused;

  assign mode_unused = mode_reg_i; // only the pattern field is consumed

  cm_fill_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_en_i    (fill_en_i),
    .trig_wr_i    (trig_wr_i),
    .trig_wdata_i (trig_wdata_i),
    .last_i       (last),
    .start_o      (start),
    .busy_o       (busy)
  );

  cm_fill_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_i  (busy),
    .addr_o  (sweep_addr),
    .last_o  (last)
  );

  // pattern frozen at the start edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pat_q <= '0;
    else if (start) pat_q <= mode_reg_i[PAT_LSB +: PAT_W];
  end

  cm_fill_wmux #(.AW(AW), .WORD_W(WORD_W), .PAT_W(PAT_W)) u_wmux (
    .busy_i       (busy),
    .pat_i        (pat_q),
    .sweep_addr_i (sweep_addr),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o)
  );

  assign busy_o = busy;
  assign trig_o = busy;
endmodule

// File: rtl/cm_fill_engine_chk.sv
module cm_fill_engine_chk #(
  parameter int unsigned DEPTH        = 2048,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned PAT_W        = 5,
  parameter int unsigned FRAME_CYCLES = 1024,
  localparam int unsigned AW          = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fill_en_i,
  input logic              trig_wr_i,
  input logic              trig_wdata_i,
  input logic              host_we_i,
  input logic [AW-1:0]     host_addr_i,
  input logic [WORD_W-1:0] host_wdata_i,
  input logic              trig_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam int unsigned LOW_W = WORD_W - PAT_W;

  logic go;
  assign go = trig_wr_i && trig_wdata_i && fill_en_i;

  int unsigned run_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r1: assert (!busy_o && !trig_o);
    end
  end

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && go |=> busy_o && trig_o && mem_we_o && mem_addr_o == '0);

  p_ascend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mem_addr_o != LAST_ADDR |=> busy_o && mem_we_o && mem_addr_o == $past(mem_addr_o) + 1'b1);

  p_low_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> mem_wdata_o[LOW_W-1:0] == '0);

  p_word_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_wdata_o));

  p_self_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mem_addr_o == LAST_ADDR |=> !busy_o && !trig_o);

  p_frame_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len <= 2 * FRAME_CYCLES);

  p_no_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !go |=> !busy_o && !trig_o);

  p_host_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> mem_we_o == host_we_i && (!host_we_i || (mem_addr_o == host_addr_i && mem_wdata_o == host_wdata_i)));
endmodule

bind cm_fill_engine cm_fill_engine_chk #(
  .DEPTH(DEPTH), .WORD_W(WORD_W), .PAT_W(PAT_W), .FRAME_CYCLES(FRAME_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_en_i    (fill_en_i),
  .trig_wr_i    (trig_wr_i),
  .trig_wdata_i (trig_wdata_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .trig_o       (trig_o),
  .busy_o       (busy_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o)
);

// File: tb/cm_fill_engine_tb.sv
module cm_fill_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2048;
  localparam int AW         = 11;
  localparam int NVEC       = 5;
  // {mode register value, expected word}
  localparam logic [31:0] VECS [NVEC] = '{
    {16'h03E0, 16'hF800},
    {16'h0020, 16'h0800},
    {16'hFC1F, 16'h0000},
    {16'h0140, 16'h5000},
    {16'h02A0, 16'hA800}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_en = 1'b0, trig_wr = 1'b0, trig_wdata = 1'b0;
  logic [15:0] mode_reg = '0;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic trig, busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;

  logic [15:0] mem [DEPTH];
  int checks = 0, errors = 0;
  int we_seen = 0;
  int mon_err = 0;
  int exp_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cm_fill_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fill_en_i(fill_en), .trig_wr_i(trig_wr),
    .trig_wdata_i(trig_wdata), .mode_reg_i(mode_reg), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .trig_o(trig),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  always @(negedge clk) begin
    if (mem_we) we_seen++;
    if (busy) begin
      if (!mem_we || int'(mem_addr) != exp_addr) mon_err++;
      exp_addr++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_mem(input logic [15:0] exp, input string tag);
    int bad = 0;
    int first = 0;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== exp) begin
        if (bad == 0) first = i;
        bad++;
      end
    check(bad == 0, tag, bad == 0 ? exp : mem[first], exp);
  endtask

  // disturb: host write, pattern change, enable drop and trigger writes mid-sweep
  task automatic run_fill(input logic [15:0] mode, input bit disturb, output int cycles);
    @(negedge clk);
    mode_reg = mode; trig_wr = 1'b1; trig_wdata = 1'b1;
    exp_addr = 0; mon_err = 0;
    @(negedge clk);
    trig_wr = 1'b0;
    check(busy && trig && mem_addr == '0, "R2 start", {trig, busy}, 3);
    cycles = 0;
    while (busy) begin
      cycles++;
      if (disturb && cycles == 10) begin
        host_we = 1'b1; host_addr = 11'd5; host_wdata = 16'h1234;
        mode_reg = 16'h0000; fill_en = 1'b0; trig_wr = 1'b1; trig_wdata = 1'b0;
      end
      if (disturb && cycles == 14) begin
        trig_wdata = 1'b1; fill_en = 1'b1;
      end
      if (disturb && cycles == 20) begin
        host_we = 1'b0; trig_wr = 1'b0; trig_wdata = 1'b0;
      end
      @(negedge clk);
    end
    check(mon_err == 0, "R3 ascending one word per clock", mon_err, 0);
  endtask

  initial begin
    int cyc;
    fill_en = 1'b1;
    #(CLK_PERIOD*3);
    @(negedge clk);
    check(!trig && !busy && !mem_we, "R1 in reset", {trig, busy, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!trig && !busy && !mem_we, "R1 after reset", {trig, busy, mem_we}, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_fill(VECS[v][31:16], 1'b0, cyc);
      check(cyc == DEPTH, "R5 sweep length", cyc, DEPTH);
      check(!trig && !busy, "R5 self clear", {trig, busy}, 0);
      check_mem(VECS[v][15:0], "R4 contents");
    end

    // R7: idle host write passes through
    @(negedge clk);
    host_we = 1'b1; host_addr = 11'd7; host_wdata = 16'h1234;
    #1;
    check(mem_we && mem_addr == 11'd7 && mem_wdata == 16'h1234, "R7 pass through", mem_wdata, 16'h1234);
    @(negedge clk);
    host_we = 1'b0;
    check(mem[7] == 16'h1234, "R7 written", mem[7], 16'h1234);

    // R6: trigger with enable low
    fill_en = 1'b0;
    we_seen = 0;
    @(negedge clk);
    mode_reg = 16'h03E0; trig_wr = 1'b1; trig_wdata = 1'b1;
    @(negedge clk);
    trig_wr = 1'b0;
    check(!trig && !busy, "R6 trigger ignored", {trig, busy}, 0);
    repeat (4) @(negedge clk);
    check(we_seen == 0 && !busy, "R6 no writes", we_seen, 0);
    check(mem[7] == 16'h1234 && mem[8] == 16'hA800, "R6 memory unchanged", mem[8], 16'hA800);
    fill_en = 1'b1;

    // R8, R9, R4: disturbed sweep
    run_fill(16'hFD5F, 1'b1, cyc);
    check(cyc == DEPTH, "R9 no restart or abort", cyc, DEPTH);
    check(mem[5] == 16'h5000, "R8 host write blocked", mem[5], 16'h5000);
    check_mem(16'h5000, "R4 pattern frozen and stray bits ignored");
    check(!trig, "R5 trigger cleared", trig, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule